// File: doc/BRIEF.md
# Programmable DDR Burst Column Sequencer

This block turns one burst command into the column addresses of every data beat of that burst. A controller programs the burst length (2, 4 or 8 beats) and the wrap order (sequential or interleaved) through a small load port. It then issues commands, each carrying a starting column. The block presents two column addresses on every clock: the beat for the rising half and the beat for the falling half. This matches a double-data-rate data path, so a burst of N beats occupies N/2 clocks.

Within a burst only the low log2(N) bits of the column move. The bits above them are taken from the start column unchanged. A flag marks the clock that carries the final pair. A one-clock done pulse follows on the next clock, which a controller can use to launch an auto-precharge. A command that arrives while a burst is running cuts that burst short and starts the new one. The column width is a parameter: 10 bits suit a byte-wide device and 9 bits suit a 16-bit device.

Top module: `ddr_burst_addr_gen`

## Requirements
- R1: After reset no beat pair is valid, no done pulse is present, and the mode register holds length 2 with sequential order.
- R2: A command sampled on a clock edge makes the first beat pair valid from that edge on. The burst lasts N/2 clocks, with two addresses per clock (beats 2p and 2p+1 on clock p, in that order). `beat_valid` then drops unless another command arrives.
- R3: In sequential order, beat k carries the start column's low log2(N) bits plus k, wrapped modulo N. The upper column bits equal those of the start column.
- R4: In interleaved order, beat k carries the start column's low log2(N) bits XORed with k. The upper column bits are unchanged.
- R5: The length code on `mode_len` is 2'b01 for 2 beats, 2'b10 for 4 beats and 2'b11 for 8 beats. A load with code 2'b00 is ignored, and the whole mode register keeps its previous value.
- R6: `mode_order` = 0 selects sequential order and 1 selects interleaved order. Both are written by a load that carries a legal length code.
- R7: A burst uses the mode held when its command is sampled. A load in the same cycle as a command, or during a burst, affects only later commands.
- R8: A command during a running burst truncates it. The next clock shows pair 0 of the new burst.
- R9: `last_pair` is high exactly on the clock that shows the final pair of a burst. `burst_done` is high on the following clock only. A burst cut short before its final pair gives no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Writes the mode register |
| mode_len | input | 2 | Burst length code |
| mode_order | input | 1 | Wrap order, 0 sequential, 1 interleaved |
| cmd_valid | input | 1 | Starts a burst |
| cmd_col | input | COL_W | Starting column of the burst |
| beat_valid | output | 1 | A beat pair is presented |
| col_first | output | COL_W | Column of the rising-half beat |
| col_second | output | COL_W | Column of the falling-half beat |
| last_pair | output | 1 | Final pair of the burst is presented |
| burst_done | output | 1 | One-clock pulse after the final pair |

## Verification
The embedded properties assume that `rst_n` is applied for at least one clock before use. They make no assumption about how closely commands follow each other, so back-to-back, truncating and overlapping-load traffic is legal. The bench changes inputs only well after each rising edge and holds them for one full clock. It mixes every legal length with both orders, reserved-code loads, loads coinciding with commands, and truncations on both the middle and the final pair.

// File: rtl/ddr_burst_pkg.sv
package ddr_burst_pkg;

  localparam int LOW_W = 3;

  typedef enum logic [1:0] {
    BL_RSVD  = 2'b00,
    BL_TWO   = 2'b01,
    BL_FOUR  = 2'b10,
    BL_EIGHT = 2'b11
  } blen_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  typedef struct packed {
    blen_e  len;
    order_e ord;
  } mode_t;

  function automatic logic [3:0] beats_of(blen_e l);
    case (l)
      BL_FOUR:  return 4'd4;
      BL_EIGHT: return 4'd8;
      default:  return 4'd2;
    endcase
  endfunction

  function automatic logic [LOW_W-1:0] wrap_mask(blen_e l);
    logic [3:0] n;
    n = beats_of(l) - 4'd1;
    return n[LOW_W-1:0];
  endfunction

  function automatic logic [LOW_W-1:0] beat_low(logic [LOW_W-1:0] lo,
                                                logic [LOW_W-1:0] k,
                                                mode_t            m);
    logic [LOW_W-1:0] msk;
    msk = wrap_mask(m.len);
    if (m.ord == ORD_ILV) return (lo ^ k) & msk;
    else                  return (lo + k) & msk;
  endfunction

endpackage

// File: rtl/ddr_burst_mode_reg.sv
module ddr_burst_mode_reg
  import ddr_burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] len_in,
  input  logic       ord_in,
  output mode_t      mode
);

  logic load_ok;
  assign load_ok = load && (len_in != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '{len: BL_TWO, ord: ORD_SEQ};
    end else if (load_ok) begin
      mode <= '{len: blen_e'(len_in), ord: order_e'(ord_in)};
    end
  end

  assert_len_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode.len != BL_RSVD);

  assert_rsvd_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && len_in == 2'b00) |=> $stable(mode));

endmodule

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq
  import ddr_burst_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int PAIR_W = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] cmd_col,
  input  mode_t            cur_mode,
  output logic             active,
  output logic [PAIR_W-1:0] pair_idx,
  output logic [COL_W-1:0] start_col,
  output mode_t            burst_mode,
  output logic             last_pair,
  output logic             done
);

  logic [3:0] pairs;
  logic [3:0] last_idx;

  assign pairs     = beats_of(burst_mode.len) >> 1;
  assign last_idx  = pairs - 4'd1;
  assign last_pair = active && ({{(4-PAIR_W){1'b0}}, pair_idx} == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      pair_idx   <= '0;
      start_col  <= '0;
      burst_mode <= '{len: BL_TWO, ord: ORD_SEQ};
      done       <= 1'b0;
    end else begin
      done <= last_pair;
      if (cmd_valid) begin
        active     <= 1'b1;
        pair_idx   <= '0;
        start_col  <= cmd_col;
        burst_mode <= cur_mode;
      end else if (active) begin
        if (last_pair) begin
          active   <= 1'b0;
          pair_idx <= '0;
        end else begin
          pair_idx <= pair_idx + 1'b1;
        end
      end
    end
  end

  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ({{(4-PAIR_W){1'b0}}, pair_idx} < pairs));

  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last_pair |=> done);

  assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(active));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (active && pair_idx == '0 && start_col == $past(cmd_col)));

  assert_mode_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !$past(cmd_valid)) |-> $stable(burst_mode));

endmodule

// File: rtl/ddr_burst_lane.sv
module ddr_burst_lane
  import ddr_burst_pkg::*;
#(
  parameter int COL_W = 10
)(
  input  logic [COL_W-1:0] start_col,
  input  mode_t            mode,
  input  logic [LOW_W-1:0] beat_k,
  output logic [COL_W-1:0] col
);

  logic [LOW_W-1:0] low_kept;
  logic [LOW_W-1:0] low_moved;

  assign low_moved = beat_low(start_col[LOW_W-1:0], beat_k, mode);
  assign low_kept  = start_col[LOW_W-1:0] & ~wrap_mask(mode.len);
  assign col       = {start_col[COL_W-1:LOW_W], low_kept | low_moved};

endmodule

// File: rtl/ddr_burst_addr_gen.sv
module ddr_burst_addr_gen
  import ddr_burst_pkg::*;
#(
  parameter int COL_W = 10
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [1:0]       mode_len,
  input  logic             mode_order,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] cmd_col,
  output logic             beat_valid,
  output logic [COL_W-1:0] col_first,
  output logic [COL_W-1:0] col_second,
  output logic             last_pair,
  output logic             burst_done
);

  localparam int BEATS_PER_CLK = 2;
  localparam int MAX_BEATS     = 1 << LOW_W;
  localparam int PAIR_W        = $clog2(MAX_BEATS / BEATS_PER_CLK);

  mode_t             cur_mode;
  mode_t             burst_mode;
  logic              active;
  logic [PAIR_W-1:0] pair_idx;
  logic [COL_W-1:0]  start_col;
  logic [COL_W-1:0]  beat_col [BEATS_PER_CLK];

  ddr_burst_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (mode_load),
    .len_in (mode_len),
    .ord_in (mode_order),
    .mode   (cur_mode)
  );

  ddr_burst_seq #(.COL_W(COL_W), .PAIR_W(PAIR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_col    (cmd_col),
    .cur_mode   (cur_mode),
    .active     (active),
    .pair_idx   (pair_idx),
    .start_col  (start_col),
    .burst_mode (burst_mode),
    .last_pair  (last_pair),
    .done       (burst_done)
  );

  for (genvar g = 0; g < BEATS_PER_CLK; g++) begin : g_lane
    logic [LOW_W-1:0] k;
    assign k = {pair_idx, (g == 1) ? 1'b1 : 1'b0};
    ddr_burst_lane #(.COL_W(COL_W)) u_lane (
      .start_col (start_col),
      .mode      (burst_mode),
      .beat_k    (k),
      .col       (beat_col[g])
    );
  end

  assign beat_valid = active;
  assign col_first  = beat_col[0];
  assign col_second = beat_col[1];

  assert_pair_distinct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (col_first != col_second));

  assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last_pair |-> beat_valid);

  assert_cmd_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> beat_valid);

  assert_upper_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid) && !$past(cmd_valid)) |->
      (col_first[COL_W-1:LOW_W] == $past(col_first[COL_W-1:LOW_W])));

endmodule

// File: tb/tb_ddr_burst_addr_gen.sv
module tb_ddr_burst_addr_gen;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_load = 1'b0;
  logic [1:0]       mode_len = 2'b00;
  logic             mode_order = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [COL_W-1:0] cmd_col = '0;
  logic             beat_valid;
  logic [COL_W-1:0] col_first;
  logic [COL_W-1:0] col_second;
  logic             last_pair;
  logic             burst_done;

  int checks = 0;
  int failures = 0;
  string phase_req = "R1";

  // behavioural model state
  int qa[$];
  int qb[$];
  bit ql[$];
  int m_len = 2;
  bit m_ilv = 1'b0;
  bit exp_done = 1'b0;

  always #5 clk = ~clk;

  ddr_burst_addr_gen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_len(mode_len),
    .mode_order(mode_order), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
    .beat_valid(beat_valid), .col_first(col_first), .col_second(col_second),
    .last_pair(last_pair), .burst_done(burst_done)
  );

  function automatic int ref_col(int start, int k, int n, bit ilv);
    int base;
    int off;
    base = start - (start % n);
    off  = start % n;
    if (ilv) return base + (off ^ k);
    return base + ((off + k) % n);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      qa.delete(); qb.delete(); ql.delete();
      m_len = 2; m_ilv = 1'b0; exp_done = 1'b0;
    end else begin
      exp_done = (qa.size() > 0) && ql[0];
      if (qa.size() > 0) begin
        void'(qa.pop_front()); void'(qb.pop_front()); void'(ql.pop_front());
      end
      if (cmd_valid) begin
        qa.delete(); qb.delete(); ql.delete();
        for (int p = 0; p < m_len / 2; p++) begin
          qa.push_back(ref_col(int'(cmd_col), 2 * p, m_len, m_ilv));
          qb.push_back(ref_col(int'(cmd_col), 2 * p + 1, m_len, m_ilv));
          ql.push_back(p == m_len / 2 - 1);
        end
      end
      if (mode_load && mode_len != 2'b00) begin
        m_len = (mode_len == 2'b01) ? 2 : (mode_len == 2'b10) ? 4 : 8;
        m_ilv = mode_order;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1", "valid in reset", int'(beat_valid), 0);
      chk("R1", "done in reset", int'(burst_done), 0);
    end else begin
      chk("R2", "beat_valid", int'(beat_valid), (qa.size() > 0) ? 1 : 0);
      chk("R9", "last_pair", int'(last_pair), (qa.size() > 0 && ql[0]) ? 1 : 0);
      chk("R9", "burst_done", int'(burst_done), exp_done ? 1 : 0);
      if (qa.size() > 0) begin
        chk(phase_req, "col_first", int'(col_first), qa[0]);
        chk(phase_req, "col_second", int'(col_second), qb[0]);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic issue(int col);
    cmd_valid = 1'b1;
    cmd_col   = COL_W'(col);
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic load_mode(logic [1:0] len, bit ilv);
    mode_load  = 1'b1;
    mode_len   = len;
    mode_order = ilv;
    step();
    mode_load  = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1: default mode is 2 beats sequential
    phase_req = "R1";
    issue(5); idle(2);
    // R3: sequential wrap, upper bits preserved
    phase_req = "R3";
    load_mode(2'b10, 1'b0);
    issue('h102); idle(3);
    issue('h3FF); idle(3);
    load_mode(2'b11, 1'b0);
    issue('h2A5); idle(5);
    // R6 and R4: interleaved order
    phase_req = "R6";
    load_mode(2'b11, 1'b1);
    issue('h0F3); idle(5);
    phase_req = "R4";
    load_mode(2'b10, 1'b1);
    issue('h001); idle(3);
    issue('h17E); idle(3);
    // R5: reserved code leaves the mode unchanged (still 4 beats interleaved)
    phase_req = "R5";
    load_mode(2'b00, 1'b0);
    issue('h0C6); idle(3);
    load_mode(2'b01, 1'b1);
    issue('h033); idle(2);
    // R7: load with the command and during a burst affects later bursts only
    phase_req = "R7";
    load_mode(2'b10, 1'b1);
    mode_load = 1'b1; mode_len = 2'b11; mode_order = 1'b0;
    issue('h20B);
    mode_load = 1'b0;
    idle(3);
    issue('h20B);
    load_mode(2'b01, 1'b1);
    idle(5);
    issue('h044); idle(2);
    // R8: truncation mid-burst and on the final pair
    phase_req = "R8";
    load_mode(2'b11, 1'b0);
    issue('h013); step();
    issue('h0A6); idle(5);
    load_mode(2'b10, 1'b1);
    issue('h1F2);
    issue('h1F5); step();
    issue('h300); idle(3);
    load_mode(2'b01, 1'b0);
    for (int i = 0; i < 6; i++) issue(i * 37);
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule